// File: doc/BRIEF.md
# Multi-Region Power Demand Modulator

This block turns a power-demand code from a voltage regulation loop into the two commands a peak-current-mode flyback stage needs. The first is a peak-current setpoint, given in millivolts of current-sense threshold. The second is a one-clock pulse that starts each switching cycle.

The demand range is split into five regions by fixed breakpoints. Depending on the region, the block holds one quantity constant and ramps the other, or ramps both together:

- At light load it holds a minimum peak and varies only frequency.
- In the next region it holds a low fixed frequency and ramps the peak.
- In the middle region it holds the peak and ramps frequency up to nominal.
- In the normal-load region it holds nominal frequency and ramps the peak.
- In the overload region it raises both.

A phase accumulator produces the cycle-start pulses. Each switching cycle runs with a single setpoint, because new values are taken up only on a cycle-start pulse. A sample-enable pulse for the output-sensing loop comes with each cycle start, but its rate is limited to a maximum sample rate.

Top module: `dmod_top`

## Requirements
- R1: Demand codes above 1000 are treated as 1000: any code from 1001 to 1023 gives peak 800 mV and the 120 kHz increment.
- R2: For demand 0 to 124, the peak setpoint is 172 mV. The accumulator increment is interpolated linearly from the 200 Hz increment at 0 to the 30 kHz increment at 125. Each breakpoint increment is floor(f·2^32/CLK_HZ), and interpolation truncates.
- R3: For demand 125 to 299, the increment is the 30 kHz value. The peak is 172 + floor(228·(d−125)/175) mV.
- R4: For demand 300 to 449, the peak is 400 mV. The increment is interpolated linearly from the 30 kHz increment to the 60 kHz increment over the region.
- R5: For demand 450 to 699, the increment is the 60 kHz value. The peak is 400 + floor(240·(d−450)/250) mV.
- R6: For demand 700 to 1000, the peak is 640 + floor(160·(d−700)/300) mV. The increment is interpolated from the 60 kHz increment to the 120 kHz increment, reaching 800 mV and 120 kHz at 1000.
- R7: The peak setpoint is never below 172 mV and never above 800 mV.
- R8: The peak setpoint and increment change only on the clock edge that ends a cycle-start pulse. A demand change between pulses leaves the peak output unchanged until the next pulse.
- R9: On each 32-bit accumulator overflow, cycle_start_o is high for exactly one clock. Cycle-start pulses are therefore spaced floor(2^32/inc) or floor(2^32/inc)+1 clocks apart.
- R10: sample_en_o is high only together with cycle_start_o. It is high for a cycle start only when at least SMP_MIN_CLKS clocks have passed since the previous sample pulse. At frequencies whose period is at least SMP_MIN_CLKS, every cycle start carries a sample pulse.
- R11: During reset and after its release, the peak is 172 mV and the increment is the 200 Hz value. Both pulse outputs are low until the first accumulator overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (CLK_HZ) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| demand_i | input | 10 | Power demand in per-mille, 0 to 1000 |
| peak_mv_o | output | 10 | Peak current-sense threshold setpoint in mV |
| cycle_start_o | output | 1 | One-clock pulse that starts a switching cycle |
| sample_en_o | output | 1 | Rate-limited sample enable for the output-sensing loop |

## Verification
A new demand reaches the peak output on the first clock edge after the next cycle-start pulse. The bench therefore waits for a pulse at a falling edge, steps one clock, and only then compares the peak. The new increment first governs the interval that follows the load, but that interval still carries the accumulator residue from the old rate. For this reason the bench skips one interval and times the next full one against the floor/floor+1 window. Sample pulses are checked in the same falling-edge sample as their cycle start, by counting clocks between them.

// File: rtl/dmod_pkg.sv
package dmod_pkg;

  localparam int unsigned NUM_BP  = 6;
  localparam int unsigned NUM_REG = NUM_BP - 1;
  localparam int unsigned DEM_FULL = 1000;

  function automatic int unsigned bp_demand(input int unsigned idx);
    case (idx)
      0: return 0;
      1: return 125;
      2: return 300;
      3: return 450;
      4: return 700;
      default: return 1000;
    endcase
  endfunction

  function automatic int unsigned bp_peak_mv(input int unsigned idx);
    case (idx)
      0, 1: return 172;
      2, 3: return 400;
      4: return 640;
      default: return 800;
    endcase
  endfunction

  function automatic int unsigned bp_freq_hz(input int unsigned idx);
    case (idx)
      0: return 200;
      1, 2: return 30000;
      3, 4: return 60000;
      default: return 120000;
    endcase
  endfunction

  function automatic longint unsigned freq_to_inc(input int unsigned f_hz,
                                                  input int unsigned acc_w,
                                                  input longint unsigned clk_hz);
    return (longint'(f_hz) << acc_w) / clk_hz;
  endfunction

endpackage

// File: rtl/dmod_map.sv
module dmod_map
  import dmod_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 100_000_000,
  parameter int unsigned     ACC_W  = 32,
  parameter int unsigned     DEM_W  = 10,
  parameter int unsigned     PEAK_W = 10
) (
  input  logic [DEM_W-1:0]  demand_i,
  output logic [PEAK_W-1:0] peak_nxt_o,
  output logic [ACC_W-1:0]  inc_nxt_o
);

  logic [63:0] dem_sat;
  logic [NUM_REG-1:0] hit;
  logic [PEAK_W-1:0] pk_c [NUM_REG];
  logic [ACC_W-1:0]  in_c [NUM_REG];

  always_comb begin
    if (64'(demand_i) > 64'(DEM_FULL)) dem_sat = 64'(DEM_FULL);
    else                               dem_sat = 64'(demand_i);
  end

  for (genvar g = 0; g < NUM_REG; g++) begin : g_region
    localparam longint unsigned D0 = longint'(bp_demand(g));
    localparam longint unsigned D1 = longint'(bp_demand(g + 1));
    localparam longint unsigned P0 = longint'(bp_peak_mv(g));
    localparam longint unsigned P1 = longint'(bp_peak_mv(g + 1));
    localparam longint unsigned I0 = freq_to_inc(bp_freq_hz(g), ACC_W, CLK_HZ);
    localparam longint unsigned I1 = freq_to_inc(bp_freq_hz(g + 1), ACC_W, CLK_HZ);
    localparam bit LAST = (g == NUM_REG - 1);

    logic [63:0] off;
    logic [63:0] pk_w;
    logic [63:0] in_w;

    always_comb begin
      off  = (dem_sat >= D0) ? (dem_sat - D0) : 64'd0;
      pk_w = P0 + ((P1 - P0) * off) / (D1 - D0);
      in_w = I0 + ((I1 - I0) * off) / (D1 - D0);
      pk_c[g] = PEAK_W'(pk_w);
      in_c[g] = ACC_W'(in_w);
      hit[g]  = (dem_sat >= D0) && (LAST || (dem_sat < D1));
    end
  end

  always_comb begin
    peak_nxt_o = pk_c[0];
    inc_nxt_o  = in_c[0];
    for (int r = 0; r < NUM_REG; r++) begin
      if (hit[r]) begin
        peak_nxt_o = pk_c[r];
        inc_nxt_o  = in_c[r];
      end
    end
  end

endmodule

// File: rtl/dmod_phase.sv
module dmod_phase #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] inc_i,
  output logic             start_o
);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic             start_q, start_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, inc_i};
    acc_d   = sum[ACC_W-1:0];
    start_d = sum[ACC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      start_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      start_q <= start_d;
    end
  end

  assign start_o = start_q;

endmodule

// File: rtl/dmod_smp_gate.sv
module dmod_smp_gate #(
  parameter int unsigned SMP_MIN_CLKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic smp_o
);

  localparam int unsigned CNT_W = $clog2(SMP_MIN_CLKS + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SMP_MIN_CLKS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic ready;
  logic fire;

  always_comb begin
    ready = (cnt_q >= CNT_MAX);
    fire  = start_i && ready;
    if (fire)        cnt_d = CNT_W'(1);
    else if (!ready) cnt_d = cnt_q + CNT_W'(1);
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_MAX;
    else        cnt_q <= cnt_d;
  end

  assign smp_o = fire;

endmodule

// File: rtl/dmod_top.sv
module dmod_top
  import dmod_pkg::*;
#(
  parameter longint unsigned CLK_HZ       = 100_000_000,
  parameter int unsigned     ACC_W        = 32,
  parameter int unsigned     DEM_W        = 10,
  parameter int unsigned     PEAK_W       = 10,
  parameter int unsigned     SMP_MIN_CLKS = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEM_W-1:0]  demand_i,
  output logic [PEAK_W-1:0] peak_mv_o,
  output logic              cycle_start_o,
  output logic              sample_en_o
);

  localparam logic [PEAK_W-1:0] PEAK_RST = PEAK_W'(bp_peak_mv(0));
  localparam logic [ACC_W-1:0]  INC_RST  = ACC_W'(freq_to_inc(bp_freq_hz(0), ACC_W, CLK_HZ));

  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic [PEAK_W-1:0] peak_nxt, peak_q, peak_d;
  logic [ACC_W-1:0]  inc_nxt, inc_q, inc_d;
  logic              start;
  logic              load_en;

  dmod_map #(
    .CLK_HZ(CLK_HZ), .ACC_W(ACC_W), .DEM_W(DEM_W), .PEAK_W(PEAK_W)
  ) u_map (
    .demand_i  (demand_i),
    .peak_nxt_o(peak_nxt),
    .inc_nxt_o (inc_nxt)
  );

  always_comb begin
    load_en = start;
    peak_d  = load_en ? peak_nxt : peak_q;
    inc_d   = load_en ? inc_nxt  : inc_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      peak_q <= PEAK_RST;
      inc_q  <= INC_RST;
    end else begin
      peak_q <= peak_d;
      inc_q  <= inc_d;
    end
  end

  dmod_phase #(.ACC_W(ACC_W)) u_phase (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .inc_i  (inc_q),
    .start_o(start)
  );

  dmod_smp_gate #(.SMP_MIN_CLKS(SMP_MIN_CLKS)) u_smp (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start_i(start),
    .smp_o  (sample_en_o)
  );

  assign peak_mv_o     = peak_q;
  assign cycle_start_o = start;

endmodule

// File: rtl/dmod_chk.sv
module dmod_chk #(
  parameter int unsigned PEAK_W       = 10,
  parameter int unsigned SMP_MIN_CLKS = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PEAK_W-1:0] peak_mv_o,
  input logic              cycle_start_o,
  input logic              sample_en_o
);

  logic [31:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           gap_q <= 32'(SMP_MIN_CLKS);
    else if (sample_en_o) gap_q <= 32'd1;
    else if (gap_q != 32'hFFFF_FFFF) gap_q <= gap_q + 32'd1;
  end

  p_peak_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(peak_mv_o) >= 32'd172);

  p_peak_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(peak_mv_o) <= 32'd800);

  p_hold_between_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_start_o |=> $stable(peak_mv_o));

  p_single_clock_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start_o |=> !cycle_start_o);

  p_sample_with_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en_o |-> cycle_start_o);

  p_sample_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en_o |-> (gap_q >= 32'(SMP_MIN_CLKS)));

endmodule

bind dmod_top dmod_chk #(.PEAK_W(PEAK_W), .SMP_MIN_CLKS(SMP_MIN_CLKS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .peak_mv_o    (peak_mv_o),
  .cycle_start_o(cycle_start_o),
  .sample_en_o  (sample_en_o)
);

// File: tb/dmod_top_test.sv
module dmod_top_test;

  localparam longint unsigned CLK_HZ = 1_000_000;
  localparam int unsigned SMP_MIN = 10;
  localparam int unsigned WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] demand = '0;
  logic [9:0] peak;
  logic cstart, smp;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  dmod_top #(.CLK_HZ(CLK_HZ), .SMP_MIN_CLKS(SMP_MIN)) uut (
    .clk(clk), .rst_n(rst_n), .demand_i(demand),
    .peak_mv_o(peak), .cycle_start_o(cstart), .sample_en_o(smp)
  );

  function automatic longint unsigned inc_of(input longint unsigned f);
    return (f << 32) / CLK_HZ;
  endfunction

  function automatic longint unsigned lerp(input longint unsigned y0, input longint unsigned y1,
                                           input longint unsigned d0, input longint unsigned d1,
                                           input longint unsigned d);
    return y0 + ((y1 - y0) * (d - d0)) / (d1 - d0);
  endfunction

  function automatic int unsigned exp_peak(input int unsigned din);
    int unsigned d = (din > 1000) ? 1000 : din;
    if (d < 125) return 172;
    if (d < 300) return 172 + (228 * (d - 125)) / 175;
    if (d < 450) return 400;
    if (d < 700) return 400 + (240 * (d - 450)) / 250;
    return 640 + (160 * (d - 700)) / 300;
  endfunction

  function automatic longint unsigned exp_inc(input int unsigned din);
    longint unsigned d = (din > 1000) ? 1000 : din;
    if (d < 125) return lerp(inc_of(200), inc_of(30000), 0, 125, d);
    if (d < 300) return inc_of(30000);
    if (d < 450) return lerp(inc_of(30000), inc_of(60000), 300, 450, d);
    if (d < 700) return inc_of(60000);
    return lerp(inc_of(60000), inc_of(120000), 700, 1000, d);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // steps to the next falling edge with cycle_start high; n = clocks taken
  task automatic wait_start(input int max, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n >= 2) check(!(cstart && prev_start), "R9 pulse width", 1, 0);
      prev_start = cstart;
    end while (!cstart && n < max);
  endtask

  bit prev_start = 1'b0;

  // load a demand, skip the partial interval, then time a full interval
  task automatic run_point(input int unsigned d, input string req);
    int n;
    longint unsigned lo;
    @(negedge clk);
    demand = 10'(d);
    wait_start(6000, n);
    @(negedge clk);
    prev_start = cstart;
    check(32'(peak) == exp_peak(d), req, peak, exp_peak(d));
    wait_start(6000, n);
    wait_start(6000, n);
    lo = (64'd1 << 32) / exp_inc(d);
    check(longint'(n) >= lo && longint'(n) <= lo + 1, req, n, lo);
  endtask

  task automatic t_reset();
    bit bad_pulse = 1'b0;
    int n;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (cstart || smp) bad_pulse = 1'b1;
    end
    check(peak == 10'd172, "R11 reset peak", peak, 172);
    check(!bad_pulse, "R11 no pulses before overflow", bad_pulse, 0);
    // R8: demand changes mid-cycle, peak must hold until next start
    demand = 10'd600;
    for (int i = 0; i < 3000; i++) @(negedge clk);
    check(peak == 10'd172, "R8 hold mid-cycle", peak, 172);
    wait_start(6000, n);
    check(n > 1000, "R11 first start at 200 Hz spacing", n, 1900);
    check(smp == 1'b1, "R10 first start carries sample", smp, 1);
    @(negedge clk);
    prev_start = cstart;
    check(peak == 10'd544, "R8 R5 update after start", peak, 544);
  endtask

  task automatic t_regions();
    run_point(0,   "R2 d=0");
    run_point(62,  "R2 d=62");
    run_point(125, "R3 d=125 floor");
    run_point(200, "R3 d=200");
    run_point(375, "R4 d=375");
    run_point(450, "R5 d=450");
    run_point(699, "R5 d=699");
    run_point(850, "R6 d=850");
    run_point(1000,"R6 d=1000");
    run_point(1023,"R1 saturate");
  endtask

  task automatic t_sample_clamp();
    int starts = 0, samples = 0, gap = 0, min_gap = 1000;
    bit orphan = 1'b0;
    // demand already 1023 -> 120 kHz, period 8..9 clocks, under SMP_MIN
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      gap++;
      if (cstart) starts++;
      if (smp) begin
        samples++;
        if (!cstart) orphan = 1'b1;
        if (samples > 1 && gap < min_gap) min_gap = gap;
        gap = 0;
      end
    end
    check(!orphan, "R10 sample only with start", orphan, 0);
    check(min_gap >= SMP_MIN, "R10 sample spacing", min_gap, SMP_MIN);
    check(samples > 0 && samples < starts, "R10 clamp drops samples", samples, starts / 2);
    // 60 kHz period ~16.7 clocks >= SMP_MIN: every start samples
    run_point(500, "R5 d=500");
    starts = 0; samples = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (cstart) starts++;
      if (smp) samples++;
    end
    check(starts == samples && starts > 0, "R10 all starts sampled", samples, starts);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) @(negedge clk);
    check(peak == 10'd172 && !cstart && !smp, "R11 in reset", peak, 172);
    rst_n = 1'b1;
    t_reset();
    t_regions();
    t_sample_clamp();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule